// File: doc/BRIEF.md
# SMRAM Access Routing Decoder

This block decides, for every memory cycle the processor issues, whether the cycle is claimed by local DRAM or left for the PCI bus. It sits behind one byte-wide chipset configuration register, the SMRAM control byte. Each cycle is described by its address, a write flag, a code-fetch flag and a flag that says System Management Mode is active. The block drives a DRAM-select line and the DRAM address that the claimed cycle should use.

Two address windows are decoded. The first is the 128 KB legacy window from A0000 to BFFFF, which maps straight through to the same DRAM address. Reads and writes to it are enabled separately. A two-bit mode field sets how SMM state and cycle type gate access: Open, Protect, or Close/Lock. In Close/Lock, SMM code fetches reach DRAM while SMM data reads of the same location go to PCI. The second window is optional. It takes the 32 KB at A8000 to AFFFF and relocates it to DRAM starting at 38000. It is checked before the legacy window.

The control byte is registered and loads on a write strobe. The route decision is combinational from the registered byte and the current cycle inputs.

Top module: `smr_route_top`

## Requirements
- R1: After a synchronous reset, cfg_rdata reads 0x08, so only the relocated window is on. A read of A8000 then selects DRAM at 38000.
- R2: A write stores only bits 7:2 of cfg_wdata. Bits 1:0 always read back as zero.
- R3: A cycle whose address lies outside both A0000–BFFFF and an enabled A8000–AFFFF window gives dram_sel low.
- R4: In the legacy window, bit 7 enables reads and bit 6 enables writes. When the enable for the cycle's direction is clear, dram_sel is low in every mode.
- R5: Mode field bits 5:4 = 01 (Open): enabled legacy-window reads and writes select DRAM whether smm_act is high or low.
- R6: Mode field = 11 (Protect): enabled legacy-window cycles select DRAM only while smm_act is high.
- R7: Mode field = 00 or 10 (Close/Lock): with smm_act high, an enabled code-fetch read selects DRAM, and data reads and writes go to PCI. With smm_act low, every legacy-window cycle goes to PCI.
- R8: With bit 3 set, any cycle to A8000–AFFFF selects DRAM at address (addr − A8000) + 38000. This holds regardless of bits 7:4 and smm_act, and takes priority over the legacy rules.
- R9: A claimed legacy-window cycle drives dram_addr equal to cyc_addr.
- R10: dram_addr is zero whenever dram_sel is low.
- R11: A control write takes effect on the clock edge that samples cfg_we. Until that edge, routing follows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the control byte |
| cfg_wdata | input | 8 | Value written to the control byte |
| cfg_rdata | output | 8 | Current (masked) control byte |
| cyc_addr | input | AW (32) | Address of the current memory cycle |
| cyc_write | input | 1 | 1 = write cycle, 0 = read |
| cyc_code | input | 1 | 1 = read is an instruction fetch |
| smm_act | input | 1 | System Management Mode active |
| dram_sel | output | 1 | 1 = cycle claimed by DRAM, 0 = forward to PCI |
| dram_addr | output | AW (32) | Translated DRAM address, zero when not claimed |

## Verification
The only internal state is the control byte. If a bit is corrupted or wrongly masked, it shows up on cfg_rdata on the cycle after the write. It also changes dram_sel for the affected direction, mode or window in the same cycle a matching address is presented. A mode decode error shows only for particular combinations of smm_act, cyc_code and cyc_write, so the stimulus crosses every mode with both SMM states and all three cycle kinds. A window boundary error shows only at the first and last byte of each window, or just outside it, so those addresses are driven directly.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    MODE_CLOSE = 2'b00,
    MODE_OPEN  = 2'b01,
    MODE_LOCK  = 2'b10,
    MODE_PROT  = 2'b11
  } smr_mode_e;

  localparam int unsigned CTL_W     = 8;
  localparam int unsigned BIT_RDEN  = 7;
  localparam int unsigned BIT_WREN  = 6;
  localparam int unsigned BIT_MODEH = 5;
  localparam int unsigned BIT_MODEL = 4;
  localparam int unsigned BIT_RELOC = 3;
  localparam logic [CTL_W-1:0] CTL_MASK  = 8'hFC;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h08;
endpackage

// File: rtl/smr_ctl_reg.sv
module smr_ctl_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL & MASK;
    else if (we) q <= wdata & MASK;
  end

  a_r2_mask_kept: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == ($past(wdata) & MASK)));
endmodule

// File: rtl/smr_win_match.sv
module smr_win_match #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] SIZE = 'h1000
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  localparam logic [AW:0] LO = {1'b0, BASE};
  localparam logic [AW:0] HI = {1'b0, BASE} + {1'b0, SIZE};

  always_comb begin
    hit    = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    offset = addr - BASE;
  end
endmodule

// File: rtl/smr_legacy_policy.sv
module smr_legacy_policy
  import smr_pkg::*;
(
  input  logic      rd_en,
  input  logic      wr_en,
  input  smr_mode_e mode,
  input  logic      is_write,
  input  logic      is_code,
  input  logic      smm,
  output logic      allow
);
  logic dir_en;

  always_comb begin
    dir_en = is_write ? wr_en : rd_en;
    unique case (mode)
      MODE_OPEN:  allow = dir_en;
      MODE_PROT:  allow = dir_en && smm;
      default:    allow = dir_en && smm && !is_write && is_code;
    endcase
  end
endmodule

// File: rtl/smr_route_top.sv
module smr_route_top
  import smr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] LEG_BASE = 32'h000A_0000,
  parameter logic [AW-1:0] LEG_SIZE = 32'h0002_0000,
  parameter logic [AW-1:0] REL_BASE = 32'h000A_8000,
  parameter logic [AW-1:0] REL_SIZE = 32'h0000_8000,
  parameter logic [AW-1:0] REL_DEST = 32'h0003_8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  output logic [CTL_W-1:0] cfg_rdata,
  input  logic [AW-1:0]    cyc_addr,
  input  logic             cyc_write,
  input  logic             cyc_code,
  input  logic             smm_act,
  output logic             dram_sel,
  output logic [AW-1:0]    dram_addr
);
  logic [CTL_W-1:0] ctl;
  logic             leg_hit, rel_hit, leg_ok, rel_on;
  logic [AW-1:0]    leg_off, rel_off;
  smr_mode_e        mode;

  smr_ctl_reg #(.W(CTL_W), .MASK(CTL_MASK), .RST_VAL(CTL_RESET)) u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(ctl)
  );

  smr_win_match #(.AW(AW), .BASE(LEG_BASE), .SIZE(LEG_SIZE)) u_leg_win (
    .addr(cyc_addr), .hit(leg_hit), .offset(leg_off)
  );

  smr_win_match #(.AW(AW), .BASE(REL_BASE), .SIZE(REL_SIZE)) u_rel_win (
    .addr(cyc_addr), .hit(rel_hit), .offset(rel_off)
  );

  assign mode   = smr_mode_e'(ctl[BIT_MODEH:BIT_MODEL]);
  assign rel_on = ctl[BIT_RELOC] && rel_hit;

  smr_legacy_policy u_pol (
    .rd_en(ctl[BIT_RDEN]), .wr_en(ctl[BIT_WREN]), .mode(mode),
    .is_write(cyc_write), .is_code(cyc_code), .smm(smm_act), .allow(leg_ok)
  );

  always_comb begin
    if (rel_on) begin
      dram_sel  = 1'b1;
      dram_addr = REL_DEST + rel_off;
    end else if (leg_hit && leg_ok) begin
      dram_sel  = 1'b1;
      dram_addr = LEG_BASE + leg_off;
    end else begin
      dram_sel  = 1'b0;
      dram_addr = '0;
    end
  end

  assign cfg_rdata = ctl;

  a_r3_outside_unclaimed: assert property (@(posedge clk) disable iff (rst)
    ((cyc_addr < LEG_BASE) || (cyc_addr >= LEG_BASE + LEG_SIZE)) |-> !dram_sel);

  a_r4_dir_disabled: assert property (@(posedge clk) disable iff (rst)
    (!(cfg_rdata[BIT_RELOC] && cyc_addr >= REL_BASE && cyc_addr < REL_BASE + REL_SIZE) &&
     !(cyc_write ? cfg_rdata[BIT_WREN] : cfg_rdata[BIT_RDEN])) |-> !dram_sel);

  a_r6_protect_outside_smm: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[BIT_MODEH:BIT_MODEL] == 2'b11 && !smm_act &&
     !(cfg_rdata[BIT_RELOC] && cyc_addr >= REL_BASE && cyc_addr < REL_BASE + REL_SIZE))
    |-> !dram_sel);

  a_r8_reloc_target: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[BIT_RELOC] && cyc_addr >= REL_BASE && cyc_addr < REL_BASE + REL_SIZE)
    |-> (dram_sel && dram_addr == cyc_addr - REL_BASE + REL_DEST));

  a_r10_idle_addr_zero: assert property (@(posedge clk) disable iff (rst)
    !dram_sel |-> (dram_addr == '0));
endmodule

// File: tb/sim_smr_route_top.sv
module sim_smr_route_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [31:0] cyc_addr;
  logic        cyc_write, cyc_code, smm_act;
  logic        dram_sel;
  logic [31:0] dram_addr;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  smr_route_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cyc_addr(cyc_addr), .cyc_write(cyc_write), .cyc_code(cyc_code), .smm_act(smm_act),
    .dram_sel(dram_sel), .dram_addr(dram_addr)
  );

  // {req[79:76], cfg[75:68], addr[67:36], wr[35], code[34], smm[33], sel[32], daddr[31:0]}
  localparam int NV = 22;
  localparam logic [79:0] VEC [0:NV-1] = '{
    {4'd5, 8'hD0, 32'hA0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA0000},  // R5 open read, R9 addr
    {4'd5, 8'hD0, 32'hBFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'hBFFFF},  // R5 open write top byte
    {4'd5, 8'hD0, 32'hB1234, 1'b0, 1'b0, 1'b1, 1'b1, 32'hB1234},  // R5 open in SMM
    {4'd4, 8'h50, 32'hA4000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},      // R4 read disabled, R10
    {4'd4, 8'h50, 32'hA4000, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA4000},  // R4 write enabled
    {4'd4, 8'h90, 32'hA4000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},      // R4 write disabled
    {4'd4, 8'h10, 32'hA4000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},      // R4 both disabled
    {4'd6, 8'hF0, 32'hA0100, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},      // R6 protect outside SMM
    {4'd6, 8'hF0, 32'hA0100, 1'b1, 1'b0, 1'b1, 1'b1, 32'hA0100},  // R6 protect write in SMM
    {4'd6, 8'hF0, 32'hA0100, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA0100},  // R6 protect data read in SMM
    {4'd7, 8'hC0, 32'hB0000, 1'b0, 1'b1, 1'b1, 1'b1, 32'hB0000},  // R7 close code fetch
    {4'd7, 8'hC0, 32'hB0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},      // R7 close data read
    {4'd7, 8'hC0, 32'hB0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},      // R7 close write
    {4'd7, 8'hE0, 32'hB0000, 1'b0, 1'b1, 1'b1, 1'b1, 32'hB0000},  // R7 lock code fetch
    {4'd7, 8'hE0, 32'hB0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},      // R7 lock outside SMM
    {4'd3, 8'hD0, 32'h9FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},      // R3 just below
    {4'd3, 8'hD8, 32'hC0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},      // R3 just above
    {4'd8, 8'h08, 32'hA8000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h38000},  // R8 first byte
    {4'd8, 8'h08, 32'hAFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 32'h3FFFF},  // R8 last byte
    {4'd8, 8'hC8, 32'hAC000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h3C000},  // R8 priority over close
    {4'd9, 8'hC8, 32'hA7FFF, 1'b0, 1'b1, 1'b1, 1'b1, 32'hA7FFF},  // R9 below reloc window
    {4'd8, 8'h08, 32'hB0000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0}       // R8 reloc only, legacy off
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_cyc(input logic [31:0] a, input logic w, input logic c, input logic s);
    cyc_addr = a;
    cyc_write = w;
    cyc_code = c;
    smm_act = s;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = 8'h00;
    cyc_addr = 32'h0; cyc_write = 1'b0; cyc_code = 1'b0; smm_act = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    #1;
    chk("R1 reset value", {24'h0, cfg_rdata}, 32'h08);
    put_cyc(32'hA8000, 1'b0, 1'b0, 1'b0);
    chk("R1 reset reloc sel", {31'h0, dram_sel}, 32'h1);
    chk("R1 reset reloc addr", dram_addr, 32'h38000);
    put_cyc(32'hA0000, 1'b0, 1'b0, 1'b1);
    chk("R1 reset legacy off", {31'h0, dram_sel}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr_cfg(VEC[i][75:68]);
      put_cyc(VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33]);
      chk($sformatf("R%0d vec%0d sel", VEC[i][79:76], i), {31'h0, dram_sel}, {31'h0, VEC[i][32]});
      chk($sformatf("R%0d vec%0d addr", VEC[i][79:76], i), dram_addr, VEC[i][31:0]);
    end

    // R2 masking
    wr_cfg(8'hFF);
    #1;
    chk("R2 mask FF", {24'h0, cfg_rdata}, 32'hFC);
    wr_cfg(8'h03);
    #1;
    chk("R2 mask 03", {24'h0, cfg_rdata}, 32'h00);
    put_cyc(32'hA8000, 1'b0, 1'b0, 1'b1);
    chk("R2 low bits no effect", {31'h0, dram_sel}, 32'h0);

    // R11 write takes effect only at the sampling edge
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 8'hD0;
    put_cyc(32'hA2000, 1'b0, 1'b0, 1'b0);
    chk("R11 before edge", {31'h0, dram_sel}, 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R11 after edge", {31'h0, dram_sel}, 32'h1);
    chk("R9 after edge addr", dram_addr, 32'hA2000);

    // R7 close mode code fetch writes still to PCI (code flag ignored on writes)
    wr_cfg(8'hC0);
    put_cyc(32'hA0000, 1'b1, 1'b1, 1'b1);
    chk("R7 write with code flag", {31'h0, dram_sel}, 32'h0);
    chk("R10 unclaimed addr", dram_addr, 32'h0);

    // R1 reset again restores default
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 re-reset value", {24'h0, cfg_rdata}, 32'h08);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule